// File: doc/BRIEF.md
# Two-Frame Jitter Test Pattern Generator

This block produces a deterministic test stream, one byte per clock, for the transmit side of a WAN interface sublayer. The stream is two frames long and then repeats. Each frame is a grid of rows and columns. The leading columns of each row are transport overhead. The next column is path overhead, and its first byte in row 0 is the path trace byte. All remaining columns form the payload. The block tracks the row, the column and the frame phase, and it flags every byte as overhead or payload. It also marks the first byte of each frame with a strobe.

A run of identical digits sits in the last overhead bytes of row 0, just ahead of the payload region. This run is all zeros in frame 0 and all ones in frame 1. Payload bytes are taken from a 2^23-1 PRBS, x^23 + x^18 + 1. The PRBS is reloaded at the first payload byte of every frame. Frame 0 loads a seed, and frame 1 loads the bitwise inverse of that seed, which keeps the disparity balanced. All other overhead bytes carry one fixed fill value, so every byte of the pattern can be known in advance. A downstream frame scrambler is applied later and is not part of this block. Dropping the test enable clears the output and rearms the generator at frame 0.

Top module: `jtp_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it, tx_byte is 0x00 and frame_start, frame_phase, oh_flag and pl_flag are all 0.
- R2: With test_en high, the byte emitted on the clock edge after test_en is first sampled high is byte 0 of a frame. frame_start is 1 exactly on row 0, column 0 of every frame, so it repeats every ROWS*COLS bytes.
- R3: frame_phase is 0 for every byte of the first frame after enable and 1 for every byte of the second frame. It then alternates frame by frame.
- R4: While enabled, oh_flag is 1 for columns 0..OH_COLS (transport overhead plus the path overhead column), and pl_flag is 1 for columns OH_COLS+1..COLS-1. Exactly one of the two flags is high on each byte.
- R5: In row 0, columns OH_COLS-CID_LEN..OH_COLS-1 carry 0x00 when frame_phase is 0 and 0xFF when frame_phase is 1.
- R6: Every other overhead byte, the path overhead column included, carries the value OH_FILL.
- R7: Payload bytes are successive 8-bit groups of the PRBS, most significant bit first. The 23-bit state s emits s[22], and the next state is {s[21:0], s[22]^s[17]}. Eight steps are taken per payload byte. The state holds across overhead bytes.
- R8: At row 0, column OH_COLS+1 (the byte after the path trace byte), the PRBS state is reloaded. It takes SEED in frame 0 and ~SEED in frame 1, and that byte is the first 8 output bits of the loaded state.
- R9: While test_en is low, the outputs are 0x00 with all strobes and flags low. The next enable restarts the pattern at frame 0, byte 0.
- R10: The output stream is periodic with a period of exactly 2*ROWS*COLS bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Pattern enable; low clears and rearms |
| tx_byte | output | 8 | Unscrambled pattern byte |
| frame_start | output | 1 | High on the first byte of each frame |
| frame_phase | output | 1 | 0 in frame 0, 1 in frame 1 |
| oh_flag | output | 1 | Byte is transport or path overhead |
| pl_flag | output | 1 | Byte is payload |

## Verification
The hardest state to reach is the reload at the start of the second frame's payload. At that point the running PRBS state must be replaced by the inverted seed rather than carried forward, and this only happens after a full frame has been emitted. The stimulus holds the enable high for two complete pattern periods and compares every byte against an independent bit-serial model. It also checks the two reload bytes explicitly against values derived from the seed. A mid-frame disable followed by a re-enable then confirms that the generator restarts from frame 0 and from the non-inverted seed, not from where it stopped.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
  localparam int PRBS_W = 23;
  localparam int TAP    = 17;
  typedef logic [PRBS_W-1:0] prbs_t;

  // Advance the LFSR by eight bit-steps.
  function automatic prbs_t prbs_adv8(prbs_t s);
    prbs_t t;
    t = s;
    for (int i = 0; i < 8; i++) begin
      t = {t[PRBS_W-2:0], t[PRBS_W-1] ^ t[TAP]};
    end
    return t;
  endfunction

  // Collect the eight emitted bits, first bit in the MSB.
  function automatic logic [7:0] prbs_out8(prbs_t s);
    prbs_t       t;
    logic [7:0]  b;
    t = s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      b = {b[6:0], t[PRBS_W-1]};
      t = {t[PRBS_W-2:0], t[PRBS_W-1] ^ t[TAP]};
    end
    return b;
  endfunction
endpackage

// File: rtl/jtp_frame_ctr.sv
module jtp_frame_ctr #(
  parameter int ROWS = 9,
  parameter int COLS = 90,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             phase
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             ph_q, ph_d;
  logic             last;

  always_comb begin
    last  = (row_q == ROW_MAX) && (col_q == COL_MAX);
    row_d = row_q;
    col_d = col_q;
    ph_d  = ph_q;
    if (!en) begin
      row_d = '0;
      col_d = '0;
      ph_d  = 1'b0;
    end else if (col_q == COL_MAX) begin
      col_d = '0;
      row_d = (row_q == ROW_MAX) ? '0 : row_q + 1'b1;
      if (last) ph_d = ~ph_q;
    end else begin
      col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      ph_q  <= ph_d;
    end
  end

  assign row   = row_q;
  assign col   = col_q;
  assign phase = ph_q;

  p_phase_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && row_q == ROW_MAX && col_q == COL_MAX) |=> (ph_q != $past(ph_q)));
  p_col_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= COL_MAX) && (row_q <= ROW_MAX));
endmodule

// File: rtl/jtp_prbs.sv
module jtp_prbs
  import jtp_pkg::*;
#(
  parameter prbs_t SEED = 23'h5A3C96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pl_now,
  input  logic       pl_start,
  input  logic       phase,
  output logic [7:0] pbyte
);
  prbs_t st_q, st_d, cur;

  always_comb begin
    cur   = pl_start ? (phase ? prbs_t'(~SEED) : SEED) : st_q;
    pbyte = prbs_out8(cur);
    st_d  = st_q;
    if (!en)         st_d = SEED;
    else if (pl_now) st_d = prbs_adv8(cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  p_hold_oh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pl_now) |=> $stable(st_q));
  p_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/jtp_byte_sel.sv
module jtp_byte_sel #(
  parameter int         ROWS    = 9,
  parameter int         COLS    = 90,
  parameter int         OH_COLS = 3,
  parameter int         CID_LEN = 2,
  parameter logic [7:0] OH_FILL = 8'hA5,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             phase,
  input  logic [7:0]       pbyte,
  output logic             pl_now,
  output logic             pl_start,
  output logic [7:0]       tx_byte,
  output logic             frame_start,
  output logic             frame_phase,
  output logic             oh_flag,
  output logic             pl_flag
);
  localparam logic [COL_W-1:0] C_POH = COL_W'(OH_COLS);
  localparam logic [COL_W-1:0] C_CID = COL_W'(OH_COLS - CID_LEN);
  localparam logic [COL_W-1:0] C_PLS = COL_W'(OH_COLS + 1);

  logic       is_toh, is_cid, row0;
  logic [7:0] byte_d;
  logic       start_d, oh_d, pl_d, ph_d;

  always_comb begin
    row0     = (row == '0);
    is_toh   = (col < C_POH);
    is_cid   = row0 && is_toh && (col >= C_CID);
    pl_now   = en && (col > C_POH);
    pl_start = pl_now && row0 && (col == C_PLS);
    if (!en)         byte_d = 8'h00;
    else if (is_cid) byte_d = {8{phase}};
    else if (pl_now) byte_d = pbyte;
    else             byte_d = OH_FILL;
    start_d = en && row0 && (col == '0);
    oh_d    = en && !pl_now;
    pl_d    = pl_now;
    ph_d    = en && phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte     <= 8'h00;
      frame_start <= 1'b0;
      frame_phase <= 1'b0;
      oh_flag     <= 1'b0;
      pl_flag     <= 1'b0;
    end else begin
      tx_byte     <= byte_d;
      frame_start <= start_d;
      frame_phase <= ph_d;
      oh_flag     <= oh_d;
      pl_flag     <= pl_d;
    end
  end

  p_start_is_oh_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (oh_flag && !pl_flag));
endmodule

// File: rtl/jtp_gen.sv
module jtp_gen
  import jtp_pkg::*;
#(
  parameter int         ROWS    = 9,
  parameter int         COLS    = 90,
  parameter int         OH_COLS = 3,
  parameter int         CID_LEN = 2,
  parameter logic [7:0] OH_FILL = 8'hA5,
  parameter prbs_t      SEED    = 23'h5A3C96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  output logic [7:0] tx_byte,
  output logic       frame_start,
  output logic       frame_phase,
  output logic       oh_flag,
  output logic       pl_flag
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             phase, pl_now, pl_start;
  logic [7:0]       pbyte;

  jtp_frame_ctr #(.ROWS(ROWS), .COLS(COLS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(test_en),
    .row(row), .col(col), .phase(phase)
  );

  jtp_prbs #(.SEED(SEED)) u_prbs (
    .clk(clk), .rst_n(rst_n), .en(test_en),
    .pl_now(pl_now), .pl_start(pl_start), .phase(phase),
    .pbyte(pbyte)
  );

  jtp_byte_sel #(
    .ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS),
    .CID_LEN(CID_LEN), .OH_FILL(OH_FILL)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .en(test_en),
    .row(row), .col(col), .phase(phase), .pbyte(pbyte),
    .pl_now(pl_now), .pl_start(pl_start),
    .tx_byte(tx_byte), .frame_start(frame_start),
    .frame_phase(frame_phase), .oh_flag(oh_flag), .pl_flag(pl_flag)
  );

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (tx_byte == 8'h00 && !frame_start && !oh_flag && !pl_flag));
  p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |=> ($countones({oh_flag, pl_flag}) == 1));
endmodule

// File: tb/tb_jtp_gen.sv
module tb_jtp_gen;
  localparam int          ROWS    = 9;
  localparam int          COLS    = 90;
  localparam int          OH_COLS = 3;
  localparam int          CID_LEN = 2;
  localparam logic [7:0]  OH_FILL = 8'hA5;
  localparam logic [22:0] SEED    = 23'h5A3C96;
  localparam int          FB      = ROWS * COLS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       test_en;
  logic [7:0] tx_byte;
  logic       frame_start, frame_phase, oh_flag, pl_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  jtp_gen #(.ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS), .CID_LEN(CID_LEN),
            .OH_FILL(OH_FILL), .SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .tx_byte(tx_byte),
    .frame_start(frame_start), .frame_phase(frame_phase),
    .oh_flag(oh_flag), .pl_flag(pl_flag)
  );

  // reference model state
  int          m_row, m_col;
  logic        m_ph;
  logic [22:0] m_lfsr;
  logic [7:0]  rec [2*FB];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    m_row = 0; m_col = 0; m_ph = 1'b0; m_lfsr = SEED;
  endtask

  function automatic logic [7:0] bits8(inout logic [22:0] s);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      b[7-i] = s[22];
      s = {s[21:0], s[22] ^ s[17]};
    end
    return b;
  endfunction

  // compare one emitted byte with the model, then advance the model
  task automatic cmp_byte();
    logic [7:0] eb;
    logic       eoh, est;
    string      tag;
    est = (m_row == 0 && m_col == 0);
    eoh = (m_col <= OH_COLS);
    if (m_row == 0 && m_col >= OH_COLS - CID_LEN && m_col < OH_COLS) begin
      eb = m_ph ? 8'hFF : 8'h00; tag = "R5 cid byte";
    end else if (eoh) begin
      eb = OH_FILL; tag = "R6 fill byte";
    end else begin
      if (m_row == 0 && m_col == OH_COLS + 1) begin
        m_lfsr = m_ph ? ~SEED : SEED; tag = "R8 reload byte";
      end else tag = "R7 prbs byte";
      eb = bits8(m_lfsr);
    end
    check(tx_byte == eb, tag, tx_byte, eb);
    check(frame_start == est, "R2 frame_start", frame_start, est);
    check(frame_phase == m_ph, "R3 frame_phase", frame_phase, m_ph);
    check({oh_flag, pl_flag} == {eoh, ~eoh}, "R4 flags", {oh_flag, pl_flag}, {eoh, ~eoh});
    m_col++;
    if (m_col == COLS) begin
      m_col = 0; m_row++;
      if (m_row == ROWS) begin m_row = 0; m_ph = ~m_ph; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; test_en = 1'b0;
    repeat (3) step();
    check({tx_byte, frame_start, frame_phase, oh_flag, pl_flag} == 0,
          "R1 reset outputs", {tx_byte, frame_start, frame_phase, oh_flag, pl_flag}, 0);
    rst_n = 1'b1;
    step();
    check({tx_byte, frame_start, frame_phase, oh_flag, pl_flag} == 0,
          "R1 after release", {tx_byte, frame_start, frame_phase, oh_flag, pl_flag}, 0);
  endtask

  task automatic t_two_periods();
    model_reset();
    test_en = 1'b1;
    for (int i = 0; i < 2 * FB; i++) begin
      step();
      rec[i] = tx_byte;
      cmp_byte();
    end
    for (int i = 0; i < 2 * FB; i++) begin
      step();
      check(tx_byte == rec[i], "R10 period repeat", tx_byte, rec[i]);
      cmp_byte();
    end
  endtask

  task automatic t_explicit_reload();
    logic [22:0] s;
    logic [7:0]  e0, e1;
    s = SEED; e0 = bits8(s);
    s = ~SEED; e1 = bits8(s);
    test_en = 1'b0; step();
    model_reset();
    test_en = 1'b1;
    for (int i = 0; i < 2 * FB; i++) begin
      step();
      if (i == OH_COLS + 1)
        check(tx_byte == e0 && pl_flag, "R8 frame0 seed byte", tx_byte, e0);
      if (i == FB + OH_COLS + 1)
        check(tx_byte == e1 && pl_flag, "R8 frame1 inverse seed byte", tx_byte, e1);
      if (i == OH_COLS - 1)
        check(tx_byte == 8'h00, "R5 frame0 cid", tx_byte, 8'h00);
      if (i == FB + OH_COLS - 1)
        check(tx_byte == 8'hFF, "R5 frame1 cid", tx_byte, 8'hFF);
      cmp_byte();
    end
  endtask

  task automatic t_disable_restart();
    test_en = 1'b0; step();
    model_reset();
    test_en = 1'b1;
    for (int i = 0; i < FB + 200; i++) begin step(); cmp_byte(); end
    test_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check({tx_byte, frame_start, frame_phase, oh_flag, pl_flag} == 0,
            "R9 disabled outputs", {tx_byte, frame_start, frame_phase, oh_flag, pl_flag}, 0);
    end
    model_reset();
    test_en = 1'b1;
    step();
    check(frame_start && !frame_phase, "R9 restart at frame0 byte0",
          {frame_start, frame_phase}, 2'b10);
    cmp_byte();
    for (int i = 1; i < FB; i++) begin step(); cmp_byte(); end
  endtask

  initial begin
    t_reset();
    t_two_periods();
    t_explicit_reload();
    t_disable_restart();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    end
    $finish;
  end
endmodule